// File: doc/BRIEF.md
# Digitally Trimmed One-Second Prescaler

This block turns a 32768 Hz oscillator clock-enable into a one-cycle pulse per second. It does not trim the oscillator itself. Instead it corrects the divider count at the divide-by-256 stage during selected seconds. Those seconds fall inside a repeating 64-minute correction cycle. A 6-bit field of an 8-bit trim byte controls the correction. The low five bits hold a magnitude N, and bit 5 gives the direction. Bits 7 and 6 belong to other logic and are ignored here. Magnitude N selects the first 2N minutes of the cycle. In each selected minute, exactly one second is shortened (positive direction) or lengthened (negative direction).

Minute boundaries arrive from the time-of-day counters as a one-cycle `minute_mark` pulse. The first pulse after reset begins minute 0 of the cycle. When a minute starts that is due for correction, the second in progress when the pulse arrives is the one corrected. A halt input freezes the divider in place.

A 512 Hz square wave for factory measurement is taken from a separate tap ahead of the correction logic, so trim settings never move it. The wave is driven only while the test enable is set, the divider is not halted, the alarm interrupt enable is clear, and either the watchdog steering bit is set or the watchdog setting is zero. In every other case the output is held low.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: During reset and on the first cycle after it, `sec_tick` and `ft_wave` are 0.
- R2: With no correction armed, `sec_tick` pulses for exactly one cycle once every 2^(STAGE_W+SUB_W) cycles in which `osc_en` is high (32768 with defaults). Bits 7:6 of `cal_ctrl` have no effect on this.
- R3: While `stop` is 1, the divider holds its position and `sec_tick` stays 0. When `stop` clears, counting resumes from the held position.
- R4: The n-th `minute_mark` after reset starts cycle minute (n-1) mod 64. That minute is corrected only if its index is below 2N, where N = `cal_ctrl[4:0]`. Minutes 62 and 63 are never corrected.
- R5: When `cal_ctrl[5]` is 1, the corrected second is one full stage (2^STAGE_W enables, 256 by default) shorter.
- R6: When `cal_ctrl[5]` is 0, the corrected second is half a stage (128 enables by default) longer.
- R7: At most one second is corrected in each corrected minute. Later seconds in that minute have the nominal length.
- R8: While the test gate is open, `ft_wave` toggles once every 2^FT_SHIFT enables (32 by default, which gives 512 Hz). The trim value and any correction in progress do not affect it.
- R9: `ft_wave` is 0 whenever `ft_bit` is 0, `stop` is 1, `alarm_irq_en` is 1, or both `wdog_steer` and `wdog_zero` are 0.
- R10: Counting advances only on cycles where `osc_en` is 1. With `osc_en` high every other cycle, a nominal second takes twice as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator clock-enable, 32768 pulses per second |
| stop | input | 1 | Halts the divider and the test tap |
| cal_ctrl | input | 8 | Trim byte: [4:0] magnitude, [5] direction (1 = faster); [7:6] ignored |
| minute_mark | input | 1 | One-cycle pulse at each minute boundary |
| ft_bit | input | 1 | Frequency-test enable |
| alarm_irq_en | input | 1 | Alarm interrupt enable; blocks the test output when set |
| wdog_steer | input | 1 | Watchdog steering bit |
| wdog_zero | input | 1 | High when the watchdog setting is all zero |
| sec_tick | output | 1 | One-cycle pulse per second |
| ft_wave | output | 1 | 512 Hz test square wave, low when not gated |

## Verification
The bench runs the block with reduced stage sizes: 8-enable stages, 4 stages per second, and a test tap of 4 enables. It reads every result at the falling edge. `sec_tick` is registered, so it appears at the falling edge that follows the rising edge that counted the last enable of a second. Second lengths are therefore measured as the spacing between two tick pulses. Expected values are 32, 24 and 36 cycles, doubled when `osc_en` runs at half rate.

A `minute_mark` is applied on the same falling edge where a tick is seen. The scheduler then arms on the next rising edge, so the second that has just begun is the corrected one. `ft_wave` trails its tap by one register. Its period is taken from rising edge to rising edge, and a gate change is given two cycles to settle before the output is checked for a steady low.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int TRIM_MAG_W = 5;

  typedef struct packed {
    logic                  up;
    logic [TRIM_MAG_W-1:0] steps;
  } trim_t;

  function automatic trim_t decode_trim(input logic [7:0] raw);
    trim_t t;
    t.up    = raw[5];
    t.steps = raw[TRIM_MAG_W-1:0];
    return t;
  endfunction
endpackage

// File: rtl/rtc_trim_sched.sv
module rtc_trim_sched #(
  parameter int MAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             minute_mark,
  input  logic [MAG_W-1:0] steps,
  input  logic             consume,
  output logic             armed
);
  localparam int IDX_W = MAG_W + 1;
  localparam logic [IDX_W-1:0] MOD_LIMIT = IDX_W'((2 ** IDX_W) - 2);

  logic [IDX_W-1:0] idx, idx_nx, span;

  assign idx_nx = idx + 1'b1;
  assign span   = {steps, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '1;
      armed <= 1'b0;
    end else if (minute_mark) begin
      idx   <= idx_nx;
      armed <= (idx_nx < span);
    end else if (consume) begin
      armed <= 1'b0;
    end
  end

  // R4: the last two minutes of the cycle are never corrected
  p_tail_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (idx < MOD_LIMIT));

  // R7: an armed correction persists until used or re-evaluated
  p_arm_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !consume && !minute_mark) |=> armed);

  // R7: a used correction is not reused in the same minute
  p_arm_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !minute_mark) |=> !armed);
endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider #(
  parameter int STAGE_W = 8,
  parameter int SUB_W   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic stop,
  input  logic armed,
  input  logic up,
  output logic sec_end
);
  localparam int LO_W = STAGE_W + 1;
  localparam logic [LO_W-1:0] NORM_LIM = LO_W'((2 ** STAGE_W) - 1);
  localparam logic [LO_W-1:0] EXT_LIM  = LO_W'((2 ** STAGE_W) + (2 ** (STAGE_W - 1)) - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = '1;
  localparam logic [SUB_W-1:0] SUB_PEN  = SUB_LAST - 1'b1;

  logic [LO_W-1:0]  lo, lo_lim;
  logic [SUB_W-1:0] hi;
  logic step, last_sub, stage_done, go_short, go_long;

  assign step       = osc_en && !stop;
  assign go_short   = armed && up;
  assign go_long    = armed && !up;
  assign last_sub   = (hi == SUB_LAST);
  assign lo_lim     = (go_long && last_sub) ? EXT_LIM : NORM_LIM;
  assign stage_done = step && (lo >= lo_lim);
  assign sec_end    = stage_done && (last_sub || (go_short && hi >= SUB_PEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (step) begin
      if (stage_done) begin
        lo <= '0;
        hi <= sec_end ? '0 : hi + 1'b1;
      end else begin
        lo <= lo + 1'b1;
      end
    end
  end

  // R6: the stage counter never passes the extended limit
  p_stage_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lo <= EXT_LIM);

  // R3: a halted divider keeps its position
  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> ($stable(lo) && $stable(hi)));

  // R10: no progress without an oscillator enable
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> ($stable(lo) && $stable(hi)));
endmodule

// File: rtl/rtc_ft_tap.sv
module rtc_ft_tap #(
  parameter int FT_SHIFT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic stop,
  input  logic gate,
  output logic ft_wave
);
  logic [FT_SHIFT:0] tap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap     <= '0;
      ft_wave <= 1'b0;
    end else begin
      if (osc_en && !stop) tap <= tap + 1'b1;
      ft_wave <= gate && tap[FT_SHIFT];
    end
  end

  // R9: a closed gate forces the test output low
  p_gate_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !ft_wave);
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int STAGE_W  = 8,
  parameter int SUB_W    = 7,
  parameter int FT_SHIFT = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       stop,
  input  logic [7:0] cal_ctrl,
  input  logic       minute_mark,
  input  logic       ft_bit,
  input  logic       alarm_irq_en,
  input  logic       wdog_steer,
  input  logic       wdog_zero,
  output logic       sec_tick,
  output logic       ft_wave
);
  trim_t cfg;
  logic  armed, sec_end, ft_gate;
  logic  unused_ctrl_bits;

  assign cfg              = decode_trim(cal_ctrl);
  assign unused_ctrl_bits = ^cal_ctrl[7:6];
  assign ft_gate          = ft_bit && !stop && !alarm_irq_en && (wdog_steer || wdog_zero);

  rtc_trim_sched #(.MAG_W(TRIM_MAG_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .minute_mark (minute_mark),
    .steps       (cfg.steps),
    .consume     (sec_end),
    .armed       (armed)
  );

  rtc_trim_divider #(.STAGE_W(STAGE_W), .SUB_W(SUB_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_en  (osc_en),
    .stop    (stop),
    .armed   (armed),
    .up      (cfg.up),
    .sec_end (sec_end)
  );

  rtc_ft_tap #(.FT_SHIFT(FT_SHIFT)) u_ft (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_en  (osc_en),
    .stop    (stop),
    .gate    (ft_gate),
    .ft_wave (ft_wave)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sec_tick <= 1'b0;
    else        sec_tick <= sec_end;
  end

  // R2: a tick lasts one cycle
  p_single_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R3: no tick follows a halted cycle
  p_stop_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sec_tick);
endmodule

// File: tb/rtc_trim_prescaler_test.sv
module rtc_trim_prescaler_test;
  localparam int CLK_PERIOD = 10;
  localparam int NOM  = 32;
  localparam int SHRT = 24;
  localparam int LNG  = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0, osc_on = 1'b0, osc_half = 1'b0;
  logic stop = 1'b0, minute_mark = 1'b0;
  logic [7:0] cal_ctrl = 8'h00;
  logic ft_bit = 1'b0, alarm_irq_en = 1'b0, wdog_steer = 1'b0, wdog_zero = 1'b0;
  logic sec_tick, ft_wave;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  rtc_trim_prescaler #(.STAGE_W(3), .SUB_W(2), .FT_SHIFT(2)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop), .cal_ctrl(cal_ctrl),
    .minute_mark(minute_mark), .ft_bit(ft_bit), .alarm_irq_en(alarm_irq_en),
    .wdog_steer(wdog_steer), .wdog_zero(wdog_zero), .sec_tick(sec_tick), .ft_wave(ft_wave)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (osc_half) osc_en <= ~osc_en;
    else          osc_en <= osc_on;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; osc_on = 1'b0; osc_half = 1'b0; stop = 1'b0; minute_mark = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    osc_on = 1'b1;
  endtask

  task automatic sync_tick();
    @(negedge clk);
    while (!sec_tick) @(negedge clk);
  endtask

  task automatic measure(input bit mark, output int len);
    sync_tick();
    if (mark) minute_mark = 1'b1;
    len = 0;
    do begin
      @(negedge clk);
      minute_mark = 1'b0;
      len++;
    end while (!sec_tick);
  endtask

  task automatic ft_period(output int len);
    logic prev;
    prev = ft_wave;
    @(negedge clk);
    while (!(ft_wave && !prev)) begin prev = ft_wave; @(negedge clk); end
    len = 0;
    prev = ft_wave;
    do begin @(negedge clk); len++; if (ft_wave && !prev) break; prev = ft_wave; end while (len < 100);
  endtask

  task automatic ft_quiet(input string req);
    int hi;
    hi = 0;
    repeat (2) @(negedge clk);
    repeat (40) begin @(negedge clk); if (ft_wave) hi++; end
    check(hi == 0, req, hi, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(sec_tick == 1'b0, "R1 tick in reset", sec_tick, 0);
    check(ft_wave == 1'b0, "R1 ft in reset", ft_wave, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sec_tick == 1'b0 && ft_wave == 1'b0, "R1 after reset", {sec_tick, ft_wave}, 0);
  endtask

  task automatic t_nominal();
    int len;
    do_reset();
    cal_ctrl = 8'h00;
    measure(1'b0, len); check(len == NOM, "R2 nominal", len, NOM);
    measure(1'b0, len); check(len == NOM, "R2 nominal repeat", len, NOM);
    cal_ctrl = 8'hC0;
    measure(1'b1, len); check(len == NOM, "R2 bits 7:6 ignored", len, NOM);
    osc_half = 1'b1;
    measure(1'b0, len);
    measure(1'b0, len); check(len == 2 * NOM, "R10 half-rate enable", len, 2 * NOM);
    osc_half = 1'b0;
  endtask

  task automatic t_stop();
    int ticks, len;
    do_reset();
    cal_ctrl = 8'h00;
    sync_tick();
    repeat (10) @(negedge clk);
    stop = 1'b1;
    ticks = 0;
    repeat (100) begin @(negedge clk); if (sec_tick) ticks++; end
    check(ticks == 0, "R3 no tick while stopped", ticks, 0);
    stop = 1'b0;
    len = 0;
    do begin @(negedge clk); len++; end while (!sec_tick && len < 200);
    check(len == NOM - 10, "R3 resume from held count", len, NOM - 10);
  endtask

  task automatic t_positive();
    int len;
    do_reset();
    cal_ctrl = 8'h21;
    measure(1'b1, len); check(len == SHRT, "R5 minute 0 shortened", len, SHRT);
    measure(1'b0, len); check(len == NOM, "R7 one second per minute", len, NOM);
    measure(1'b1, len); check(len == SHRT, "R5 minute 1 shortened", len, SHRT);
    measure(1'b1, len); check(len == NOM, "R4 minute 2 untouched for N=1", len, NOM);
  endtask

  task automatic t_negative();
    int len;
    do_reset();
    cal_ctrl = 8'h01;
    measure(1'b1, len); check(len == LNG, "R6 minute 0 lengthened", len, LNG);
    measure(1'b0, len); check(len == NOM, "R7 later second nominal", len, NOM);
  endtask

  task automatic t_full_cycle();
    int len;
    do_reset();
    cal_ctrl = 8'h3F;
    @(negedge clk);
    minute_mark = 1'b1;
    repeat (61) @(negedge clk);
    minute_mark = 1'b0;
    sync_tick();
    sync_tick();
    measure(1'b1, len); check(len == SHRT, "R4 minute 61 corrected at N=31", len, SHRT);
    measure(1'b1, len); check(len == NOM, "R4 minute 62 never corrected", len, NOM);
    measure(1'b1, len); check(len == NOM, "R4 minute 63 never corrected", len, NOM);
    measure(1'b1, len); check(len == SHRT, "R4 cycle wraps to minute 0", len, SHRT);
  endtask

  task automatic t_ftest();
    int len;
    do_reset();
    cal_ctrl = 8'h00;
    ft_bit = 1'b1; alarm_irq_en = 1'b0; wdog_steer = 1'b1; wdog_zero = 1'b0;
    ft_period(len); check(len == 8, "R8 test period", len, 8);
    cal_ctrl = 8'h3F;
    sync_tick();
    minute_mark = 1'b1; @(negedge clk); minute_mark = 1'b0;
    ft_period(len); check(len == 8, "R8 period during correction", len, 8);
    wdog_steer = 1'b0; wdog_zero = 1'b1;
    ft_period(len); check(len == 8, "R8 open via zero watchdog", len, 8);
    wdog_zero = 1'b0;
    ft_quiet("R9 steering and zero both low");
    wdog_steer = 1'b1; alarm_irq_en = 1'b1;
    ft_quiet("R9 alarm enable blocks");
    alarm_irq_en = 1'b0; ft_bit = 1'b0;
    ft_quiet("R9 test bit clear");
    ft_bit = 1'b1; stop = 1'b1;
    ft_quiet("R9 stopped");
    stop = 1'b0;
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_stop();
    t_positive();
    t_negative();
    t_full_cycle();
    t_ftest();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule